// File: doc/BRIEF.md
# Timer count-clock edge selector

This block is the count-clock front end of a single timer channel. It owns one 8-bit control register on a plain write/read bus. Three fields are packed into that register: a counter-clear selection that is only stored and handed to the channel, an edge selection, and a count-source selection. The source can be one of several internally divided clocks, one of two external pins, or the overflow/underflow pulse of a neighbouring channel. The chosen source is qualified by the edge selection. The result is a one-cycle count-enable strobe in the system clock domain, which drives the channel's counter.

A chip with five timer channels uses five copies of this block. Each copy has its own register and its own independent source choice. The `PHASE_CAPABLE` parameter marks the channels that support phase counting. On those channels an asserted phase-mode input takes the counter away from this block, and its strobe falls silent. Software is expected to reprogram the register only while the channel is stopped. A write attempted while the channel runs is refused and is recorded in a sticky flag.

Top module: `tmr_clk_front`

## Requirements
- R1: After reset the register reads 0x00, `clr_sel` is 0 and `wr_err` is 0. The register reset value selects the divide-by-1 source, so `cnt_en` is high from the first clock after reset.
- R2: A write while `run` is low stores `bus_wdata`, which then reads back on `bus_rdata` one cycle later. Bits 7:5 appear on `clr_sel`. Bits 4:3 are the edge field and bits 2:0 are the source field.
- R3: A write while `run` is high leaves the register unchanged and sets `wr_err`. `wr_err` stays set until a later write is made with `run` low, and that write clears it.
- R4: The source codes are 001 = divide-by-4, 010 = divide-by-16, 011 = divide-by-64 and 110 = divide-by-256. With edge field 00 (rising), `cnt_en` pulses exactly once in every N consecutive cycles of a divide-by-N source.
- R5: With edge field 01 (falling), `cnt_en` pulses only when the selected level goes from high to low. For an internal divide-by-N source this is one pulse per N cycles.
- R6: With edge field 1x (both), `cnt_en` pulses on every level change of the selected source, which is two pulses per source period.
- R7: The source codes are 100 = pin A and 101 = pin B, each passed through a two-flop synchroniser. A qualifying pin change driven before clock edge k produces `cnt_en` high in the cycle after edge k+2 only, and the strobe is one cycle wide.
- R8: Source 000 (divide-by-1) makes `cnt_en` high on every cycle whatever the edge field holds.
- R9: Source 111 passes `casc_in` to `cnt_en` one cycle later, cycle for cycle, and ignores the edge field.
- R10: While `phase_mode` is high on a phase-capable channel, `cnt_en` stays low. Counting resumes once `phase_mode` drops.
- R11: With pin B selected, activity on pin A produces no count pulses, and pin B edges are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Current register contents |
| run | input | 1 | Channel counter running |
| phase_mode | input | 1 | Phase-counting mode active |
| pin_a | input | 1 | External clock pin A (asynchronous) |
| pin_b | input | 1 | External clock pin B (asynchronous) |
| casc_in | input | 1 | Overflow/underflow pulse of another channel |
| clr_sel | output | 3 | Stored counter-clear selection |
| wr_err | output | 1 | Sticky refused-write flag |
| cnt_en | output | 1 | One-cycle count enable to the counter |

## Verification
Counting strobes does not tell falling-edge qualification apart from rising-edge qualification, because both give one pulse per period. The stimulus therefore holds an external pin high long enough to count the pulses it produces, then drops the pin and counts again. Rising mode must pulse only on the first step and falling mode only on the second. The exact three-cycle synchroniser latency is checked cycle by cycle from a pin change driven at a known clock phase. Each internal-divider check starts only after the stale level sample left over from a source switch has settled. It then counts over a window of exactly eight source periods, so that the expected count does not depend on the free-running prescaler's phase.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        SRC_DIV1   = 3'b000,
        SRC_DIV4   = 3'b001,
        SRC_DIV16  = 3'b010,
        SRC_DIV64  = 3'b011,
        SRC_PIN_A  = 3'b100,
        SRC_PIN_B  = 3'b101,
        SRC_DIV256 = 3'b110,
        SRC_CASC   = 3'b111
    } src_sel_e;

    typedef struct packed {
        logic [2:0] clr;
        logic [1:0] edg;
        src_sel_e   src;
    } ctrl_t;

    typedef enum logic [1:0] {
        EDGE_RISE,
        EDGE_FALL,
        EDGE_BOTH
    } edge_kind_e;

    typedef enum logic [1:0] {
        PATH_OFF,
        PATH_ALWAYS,
        PATH_PULSE,
        PATH_EDGE
    } path_kind_e;

    typedef struct packed {
        path_kind_e kind;
        edge_kind_e edg;
    } path_t;

    function automatic edge_kind_e decode_edge(input logic [1:0] f);
        if (f[1])
            return EDGE_BOTH;
        else if (f[0])
            return EDGE_FALL;
        else
            return EDGE_RISE;
    endfunction

    // Divide-by-1 and cascade sources bypass the edge field entirely.
    function automatic path_t route(input ctrl_t c, input logic phase_off);
        path_t p;
        p.edg = decode_edge(c.edg);
        if (phase_off)
            p.kind = PATH_OFF;
        else begin
            case (c.src)
                SRC_DIV1: p.kind = PATH_ALWAYS;
                SRC_CASC: p.kind = PATH_PULSE;
                default:  p.kind = PATH_EDGE;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/tcf_ctrl_reg.sv
module tcf_ctrl_reg
    import tcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             run,
    output ctrl_t            ctrl,
    output logic             wr_err
);

    ctrl_t ctrl_q;
    logic  err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else if (wr_en) begin
            if (run) begin
                err_q <= 1'b1;
            end else begin
                ctrl_q <= ctrl_t'(wdata);
                err_q  <= 1'b0;
            end
        end
    end

    assign ctrl   = ctrl_q;
    assign wr_err = err_q;

endmodule

// File: rtl/tcf_prescaler.sv
module tcf_prescaler #(
    parameter int N_TAPS   = 4,
    parameter int TAP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [N_TAPS-1:0] taps
);

    localparam int PRE_W = N_TAPS * TAP_STEP;

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Tap g is a square wave of period 2**(TAP_STEP*(g+1)).
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign taps[g] = cnt_q[TAP_STEP*(g+1)-1];
    end

endmodule

// File: rtl/tcf_sync.sv
module tcf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= '0;
                else
                    stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= '0;
                else
                    stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tcf_edge_qual.sv
module tcf_edge_qual
    import tcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  path_t path,
    input  logic  level,
    input  logic  pulse,
    output logic  cnt_en
);

    logic lvl_q;
    logic hit;
    logic en_q;

    always_comb begin
        case (path.kind)
            PATH_ALWAYS: hit = 1'b1;
            PATH_PULSE:  hit = pulse;
            PATH_EDGE: begin
                case (path.edg)
                    EDGE_RISE: hit = level & ~lvl_q;
                    EDGE_FALL: hit = ~level & lvl_q;
                    default:   hit = level ^ lvl_q;
                endcase
            end
            default:     hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            lvl_q <= level;
            en_q  <= hit;
        end
    end

    assign cnt_en = en_q;

endmodule

// File: rtl/tmr_clk_front.sv
module tmr_clk_front
    import tcf_pkg::*;
#(
    parameter int PHASE_CAPABLE = 1,
    parameter int SYNC_STAGES   = 2,
    parameter int N_TAPS        = 4,
    parameter int TAP_STEP      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             run,
    input  logic             phase_mode,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             casc_in,
    output logic [2:0]       clr_sel,
    output logic             wr_err,
    output logic             cnt_en
);

    localparam int N_PINS = 2;

    ctrl_t             ctrl;
    logic [N_TAPS-1:0] taps;
    logic [N_PINS-1:0] pins_s;
    logic              phase_off;
    logic              level;
    path_t             path;

    tcf_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .wdata  (bus_wdata),
        .run    (run),
        .ctrl   (ctrl),
        .wr_err (wr_err)
    );

    tcf_prescaler #(
        .N_TAPS   (N_TAPS),
        .TAP_STEP (TAP_STEP)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .taps (taps)
    );

    tcf_sync #(
        .W      (N_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pin_b, pin_a}),
        .q   (pins_s)
    );

    assign phase_off = (PHASE_CAPABLE != 0) && phase_mode;

    always_comb begin
        case (ctrl.src)
            SRC_DIV4:   level = taps[0];
            SRC_DIV16:  level = taps[1];
            SRC_DIV64:  level = taps[2];
            SRC_DIV256: level = taps[N_TAPS-1];
            SRC_PIN_A:  level = pins_s[0];
            SRC_PIN_B:  level = pins_s[1];
            default:    level = 1'b0;
        endcase
    end

    assign path = route(ctrl, phase_off);

    tcf_edge_qual u_qual (
        .clk    (clk),
        .rst    (rst),
        .path   (path),
        .level  (level),
        .pulse  (casc_in),
        .cnt_en (cnt_en)
    );

    assign bus_rdata = ctrl;
    assign clr_sel   = ctrl.clr;

endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
    parameter int PHASE_CAPABLE = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       run,
    input logic       phase_mode,
    input logic       casc_in,
    input logic       wr_err,
    input logic       cnt_en
);

    AST_RUN_WRITE_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && run) |=> ($stable(bus_rdata) && wr_err)); // R3

    AST_STOP_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !run) |=> (bus_rdata == $past(bus_wdata) && !wr_err)); // R2

    AST_DIV1_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[2:0] == 3'b000 && !phase_mode) |=> cnt_en); // R8

    AST_CASC_PASS: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[2:0] == 3'b111 && !phase_mode) |=> (cnt_en == $past(casc_in))); // R9

    AST_PHASE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase_mode && PHASE_CAPABLE != 0) |=> !cnt_en); // R10

endmodule

bind tmr_clk_front tcf_checker #(.PHASE_CAPABLE(PHASE_CAPABLE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .run        (run),
    .phase_mode (phase_mode),
    .casc_in    (casc_in),
    .wr_err     (wr_err),
    .cnt_en     (cnt_en)
);

// File: tb/tmr_clk_front_bench.sv
module tmr_clk_front_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       run = 1'b0;
    logic       phase_mode = 1'b0;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       casc_in = 1'b0;
    logic [2:0] clr_sel;
    logic       wr_err;
    logic       cnt_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tmr_clk_front u_tmr_clk_front (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .run        (run),
        .phase_mode (phase_mode),
        .pin_a      (pin_a),
        .pin_b      (pin_b),
        .casc_in    (casc_in),
        .clr_sel    (clr_sel),
        .wr_err     (wr_err),
        .cnt_en     (cnt_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic count_window(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(cnt_en);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold the chosen pin at lvl for n cycles, counting strobes.
    task automatic pin_hold(input bit use_b, input logic lvl, input int n, inout int c);
        if (use_b) pin_b = lvl; else pin_a = lvl;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(cnt_en);
        end
    endtask

    task automatic t_reset;
        chk("R1", "rdata after reset", int'(bus_rdata), 0);
        chk("R1", "clr_sel after reset", int'(clr_sel), 0);
        chk("R1", "wr_err after reset", int'(wr_err), 0);
        @(negedge clk);
        chk("R1", "cnt_en with reset source", int'(cnt_en), 1);
    endtask

    task automatic t_fields;
        wr_reg(8'hA5);
        chk("R2", "readback A5", int'(bus_rdata), 8'hA5);
        chk("R2", "clr_sel from bits 7:5", int'(clr_sel), 5);
        wr_reg(8'h00);
        chk("R2", "readback 00", int'(bus_rdata), 0);
    endtask

    task automatic t_run_write;
        wr_reg(8'h4A);
        run = 1'b1;
        wr_reg(8'hFF);
        chk("R3", "rdata kept during run", int'(bus_rdata), 8'h4A);
        chk("R3", "wr_err set", int'(wr_err), 1);
        idle(5);
        chk("R3", "wr_err sticky", int'(wr_err), 1);
        run = 1'b0;
        idle(1);
        wr_reg(8'h00);
        chk("R3", "wr_err cleared by stopped write", int'(wr_err), 0);
        chk("R3", "stopped write stored", int'(bus_rdata), 0);
    endtask

    task automatic t_div(input string req, input logic [7:0] cfg, input int n, input int exp);
        int c;
        wr_reg(cfg);
        idle(6);
        count_window(8 * n, c);
        chk(req, $sformatf("pulses cfg=%02h over %0d cycles", cfg, 8 * n), c, exp);
    endtask

    task automatic t_div1;
        int c;
        wr_reg(8'h08);
        idle(2);
        count_window(40, c);
        chk("R8", "div1 with falling field", c, 40);
        wr_reg(8'h10);
        idle(2);
        count_window(40, c);
        chk("R8", "div1 with both field", c, 40);
    endtask

    task automatic t_pin_edges;
        int c;
        wr_reg(8'h04);
        idle(6);
        c = 0;
        pin_hold(1'b0, 1'b1, 10, c);
        chk("R5", "rising mode pulses on rise", c, 1);
        c = 0;
        pin_hold(1'b0, 1'b0, 10, c);
        chk("R5", "rising mode quiet on fall", c, 0);
        wr_reg(8'h0C);
        idle(6);
        c = 0;
        pin_hold(1'b0, 1'b1, 10, c);
        chk("R5", "falling mode quiet on rise", c, 0);
        c = 0;
        pin_hold(1'b0, 1'b0, 10, c);
        chk("R5", "falling mode pulses on fall", c, 1);
        wr_reg(8'h14);
        idle(6);
        c = 0;
        for (int p = 0; p < 5; p++) begin
            pin_hold(1'b0, 1'b1, 6, c);
            pin_hold(1'b0, 1'b0, 6, c);
        end
        chk("R6", "both mode pin pulses", c, 10);
    endtask

    task automatic t_pin_latency;
        wr_reg(8'h04);
        idle(6);
        pin_a = 1'b1;
        @(negedge clk);
        chk("R7", "latency cycle 1", int'(cnt_en), 0);
        @(negedge clk);
        chk("R7", "latency cycle 2", int'(cnt_en), 0);
        @(negedge clk);
        chk("R7", "latency cycle 3", int'(cnt_en), 1);
        @(negedge clk);
        chk("R7", "strobe one cycle wide", int'(cnt_en), 0);
        pin_a = 1'b0;
        idle(6);
    endtask

    task automatic t_pin_b;
        int c;
        wr_reg(8'h05);
        idle(6);
        c = 0;
        for (int p = 0; p < 5; p++) begin
            pin_hold(1'b0, 1'b1, 5, c);
            pin_hold(1'b0, 1'b0, 5, c);
        end
        chk("R11", "pin A ignored with pin B source", c, 0);
        c = 0;
        for (int p = 0; p < 3; p++) begin
            pin_hold(1'b1, 1'b1, 5, c);
            pin_hold(1'b1, 1'b0, 5, c);
        end
        chk("R11", "pin B rising pulses", c, 3);
    endtask

    task automatic t_casc;
        wr_reg(8'h0F);
        idle(3);
        chk("R9", "idle cascade", int'(cnt_en), 0);
        casc_in = 1'b1;
        @(negedge clk);
        casc_in = 1'b0;
        chk("R9", "pulse one cycle later", int'(cnt_en), 1);
        @(negedge clk);
        chk("R9", "pulse ends", int'(cnt_en), 0);
        casc_in = 1'b1;
        @(negedge clk);
        chk("R9", "back-to-back first", int'(cnt_en), 1);
        @(negedge clk);
        casc_in = 1'b0;
        chk("R9", "back-to-back second", int'(cnt_en), 1);
        @(negedge clk);
        chk("R9", "back-to-back end", int'(cnt_en), 0);
    endtask

    task automatic t_phase;
        int c;
        wr_reg(8'h01);
        phase_mode = 1'b1;
        idle(2);
        count_window(64, c);
        chk("R10", "no strobes in phase mode", c, 0);
        wr_reg(8'h00);
        idle(2);
        count_window(16, c);
        chk("R10", "div1 silenced by phase mode", c, 0);
        wr_reg(8'h01);
        phase_mode = 1'b0;
        idle(6);
        count_window(32, c);
        chk("R10", "counting resumes", c, 8);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        t_reset();
        t_fields();
        t_run_write();
        t_div("R4", 8'h01, 4, 8);
        t_div("R4", 8'h02, 16, 8);
        t_div("R4", 8'h03, 64, 8);
        t_div("R4", 8'h06, 256, 8);
        t_div("R5", 8'h09, 4, 8);
        t_div("R5", 8'h0B, 64, 8);
        t_div("R6", 8'h12, 16, 16);
        t_div("R6", 8'h19, 4, 16);
        t_div1();
        t_pin_edges();
        t_pin_latency();
        t_pin_b();
        t_casc();
        t_phase();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule